// File: doc/BRIEF.md
# Oversampled External Count Input Synchronizer

This block sits in front of a timer and turns a raw external count pin into a clean, single-clock increment strobe. The instruction cycle is divided into four one-hot phase strobes (Q1 to Q4), supplied from outside. The pin is captured only on the Q2 and Q4 strobes, so it is sampled twice per instruction cycle. A rising edge is accepted only when a short window of consecutive captures reads one low sample followed by high samples. The resulting increment is held back and issued on the Q1 strobe that follows.

Two selects shape the output. With the source select cleared, the strobe marks every Q1, so the timer counts instruction cycles. With it set, the strobe follows the external pin. In that case the mode select chooses between the oversampled, synchronized path (cleared) and an unsynchronized path (set). In the unsynchronized path a rising pin level, compared with its value at the previous clock edge, drives the strobe directly. Prescaling and the counter itself are outside this block.

Top module: `ext_count_sync`

## Requirements
- R1: While reset is low, the sample history is all zeros, no increment is pending, and in synchronized external mode `cnt_en` stays 0. After reset, a pin that is then raised and held high yields exactly one increment.
- R2: The sample history shifts in `ext_in` only on clock edges where `phase[1]` (Q2) or `phase[3]` (Q4) is high. `phase` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4.
- R3: In synchronized external mode (`src_ext`=1, `async_sel`=0), an edge is recognized only when the last CONFIRM captures, oldest first, read one 0 followed by CONFIRM-1 ones (0,1,1 for the default).
- R4: After the capture that completes a recognized edge, `cnt_en` is high for exactly the next Q1 cycle. This gives one pulse per edge. With the default CONFIRM, a pin raised at the start of Q1 pulses in the fourth following cycle.
- R5: In synchronized external mode, a high or low pulse of `ext_in` that spans only one capture (two clocks) produces no increment. High and low runs of four clocks each produce one increment per high run.
- R6: In unsynchronized external mode (`src_ext`=1, `async_sel`=1), `cnt_en` is high in the cycle where `ext_in` is 1 and was 0 at the previous clock edge. It is low otherwise, including while the pin stays high.
- R7: With `src_ext`=0, `cnt_en` equals `phase[0]` in every cycle, regardless of `ext_in`.
- R8: In synchronized external mode, a pin held high for many instruction cycles produces exactly one increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 4 | One-hot phase strobes, bit 0 = Q1 through bit 3 = Q4 |
| ext_in | input | 1 | Raw external count pin |
| src_ext | input | 1 | 1 selects the external pin as the count source, 0 selects the instruction clock |
| async_sel | input | 1 | 1 bypasses synchronization, 0 uses the oversampled path |
| cnt_en | output | 1 | One-clock increment strobe for the timer |

## Verification
The bench builds the block with its default window CONFIRM = 3. With this value, two-clock glitches, four-clock runs and a held-high pin each have a distinct, hand-countable expected number of increments. The three-capture window also places the Q1 strobe exactly four cycles after a pin rise made at the start of Q1, so that latency is checked cycle by cycle. The phase strobes rotate one clock each, which puts both the single-capture rejection and the once-per-edge behaviour within reach of short patterns.

// File: rtl/ext_count_sync.sv
module ext_count_sync #(
  parameter int CONFIRM = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] phase,
  input  logic       ext_in,
  input  logic       src_ext,
  input  logic       async_sel,
  output logic       cnt_en
);

  localparam logic [CONFIRM-1:0] EDGE_PAT = {1'b0, {(CONFIRM-1){1'b1}}};

  logic [CONFIRM-1:0] hist;
  logic [CONFIRM-1:0] hist_nx;
  logic               pending;
  logic               ext_d;
  logic               sample_en;
  logic               sync_ext;
  logic               async_pulse;

  assign sample_en   = phase[1] | phase[3];
  assign sync_ext    = src_ext & ~async_sel;
  assign hist_nx     = {hist[CONFIRM-2:0], ext_in};
  assign async_pulse = ext_in & ~ext_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist    <= '0;
      pending <= 1'b0;
      ext_d   <= 1'b0;
    end else begin
      ext_d <= ext_in;
      if (sample_en)
        hist <= hist_nx;
      if (phase[0])
        pending <= 1'b0;
      else if (sample_en && sync_ext && hist_nx == EDGE_PAT)
        pending <= 1'b1;
    end
  end

  always_comb begin
    if (!src_ext)
      cnt_en = phase[0];
    else if (async_sel)
      cnt_en = async_pulse;
    else
      cnt_en = pending & phase[0];
  end

endmodule

module ext_count_sync_chk #(
  parameter int CONFIRM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         phase,
  input logic               ext_in,
  input logic               src_ext,
  input logic               async_sel,
  input logic               cnt_en,
  input logic [CONFIRM-1:0] hist,
  input logic               pending
);

  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase));

  assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(phase[1] | phase[3]) |=> $stable(hist));

  assert_pulse_on_q1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && src_ext && !async_sel) |-> phase[0]);

  assert_pending_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase[0] |=> !pending);

  assert_async_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && src_ext && async_sel) |-> ext_in);

  assert_internal_q1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_ext |-> (cnt_en == phase[0]));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (hist == '0 && !pending));

endmodule

bind ext_count_sync ext_count_sync_chk #(.CONFIRM(CONFIRM)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .ext_in(ext_in),
  .src_ext(src_ext), .async_sel(async_sel), .cnt_en(cnt_en),
  .hist(hist), .pending(pending)
);

// File: tb/sim_ext_count_sync.sv
module sim_ext_count_sync;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pcnt = 2'd0;
  logic [3:0] phase;
  logic       ext_in = 1'b0;
  logic       src_ext = 1'b1;
  logic       async_sel = 1'b0;
  logic       cnt_en;
  int checks = 0;
  int errors = 0;
  int pulses;

  // pattern (left = first clock) and expected increments
  localparam logic [20:0] VEC [NVEC] = '{
    {16'b0000000000000000, 5'd0},
    {16'b1111111111111111, 5'd1},
    {16'b0011000000000000, 5'd0},
    {16'b0011110000000000, 5'd1},
    {16'b1111000011110000, 5'd2},
    {16'b1100110011001100, 5'd0},
    {16'b0011111111000000, 5'd1}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) pcnt <= 2'd0;
    else        pcnt <= pcnt + 2'd1;
  end
  assign phase = 4'b0001 << pcnt;

  ext_count_sync u0 (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ext_in(ext_in),
    .src_ext(src_ext), .async_sel(async_sel), .cnt_en(cnt_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v);
    @(negedge clk);
    if (cnt_en) pulses++;
    ext_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: quiet during reset
    repeat (3) @(negedge clk);
    chk("R1 reset output", int'(cnt_en), 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 R5 R8: table walk
    for (int i = 0; i < NVEC; i++) begin
      pulses = 0;
      for (int j = 0; j < 16; j++) cyc(VEC[i][20 - j]);
      for (int j = 0; j < 8; j++) cyc(1'b0);
      chk($sformatf("R3/R5 vec%0d", i), pulses, int'(VEC[i][4:0]));
    end

    // R4: latency from a rise at the start of Q1
    do @(negedge clk); while (!phase[0]);
    ext_in = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk($sformatf("R4 cycle %0d", k), int'(cnt_en), (k == 4) ? 1 : 0);
    end
    pulses = 0;
    for (int j = 0; j < 40; j++) cyc(1'b1);
    chk("R8 held high", pulses, 0);
    for (int j = 0; j < 8; j++) cyc(1'b0);

    // R6: unsynchronized path
    async_sel = 1'b1;
    for (int j = 0; j < 4; j++) cyc(1'b0);
    cyc(1'b1);
    #1;
    chk("R6 rise strobe", int'(cnt_en), 1);
    @(negedge clk);
    chk("R6 one clock", int'(cnt_en), 0);
    pulses = 0;
    for (int j = 0; j < 8; j++) cyc(1'b1);
    chk("R6 held high", pulses, 0);
    cyc(1'b0);
    async_sel = 1'b0;

    // R7: instruction-clock source
    src_ext = 1'b0;
    pulses = 0;
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      chk("R7 follows Q1", int'(cnt_en), int'(phase[0]));
      if (cnt_en) pulses++;
      ext_in = (j % 3 == 0);
    end
    chk("R7 count", pulses, 4);
    src_ext = 1'b1;
    for (int j = 0; j < 8; j++) cyc(1'b0);

    // R1: reset with pin high, release with pin low
    rst_n = 1'b0; ext_in = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R1 in reset", int'(cnt_en), 0);
    end
    ext_in = 1'b0; rst_n = 1'b1;
    pulses = 0;
    for (int j = 0; j < 12; j++) cyc(1'b0);
    chk("R1 no spurious", pulses, 0);
    for (int j = 0; j < 12; j++) cyc(1'b1);
    for (int j = 0; j < 4; j++) cyc(1'b0);
    chk("R1 edge after reset", pulses, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule